// File: doc/BRIEF.md
# Programmable-Format Serial Character Transmitter

This block is the sending side of one asynchronous serial channel. Software places a character in a one-entry holding register through a single-cycle write strobe. When the shift register is free, the character moves into it and goes out on the serial line. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. Timing comes from an enable tick that runs at sixteen times the bit rate. Every bit lasts a fixed number of these ticks, so the baud divisor that makes the tick can live elsewhere.

The format inputs are static levels, normally driven by a line-control register. They select the word length, a long stop period (1.5 bits for 5-bit words, 2 bits otherwise), parity on or off, even or odd parity, and stuck parity. A break input holds the line low for as long as it is set. A loopback input holds the line at mark while the frame still runs inside the block. Two flags report progress: one shows that the holding register can take a new character, and the other shows that the transmitter has fully drained.

Top module: `ser_tx_framer`

## Requirements
- R1: While reset is high and after it is released, `tx` is 1, `hold_empty` is 1 and `all_empty` is 1 until the first write.
- R2: A frame is one start bit at 0, then the data bits starting with `wr_data[0]`. The count of data bits is 5 + `wlen` (wlen 0,1,2,3 gives 5,6,7,8). Bits above the word length are not sent.
- R3: Every start, data and parity bit stays on `tx` for exactly 16 `tick16` pulses. Clock cycles without a tick do not advance the frame.
- R4: With `stop_long` at 0 the stop period is 16 ticks at 1. With `stop_long` at 1 it is 24 ticks when `wlen` is 0 and 32 ticks for every other word length.
- R5: With `par_en` at 1 a parity bit follows the last data bit. With `par_even` at 1 the data bits plus parity hold an even number of ones. With `par_even` at 0 they hold an odd number.
- R6: With `par_en` and `par_stick` both at 1, the parity bit is the inverse of `par_even`. With `par_en` at 0, `par_stick` has no effect on the frame.
- R7: While `brk` is 1 and `loop_en` is 0, `tx` is 0. When `brk` clears, the line returns to its normal value.
- R8: While `loop_en` is 1, `tx` is 1, and the frame still runs to completion and updates both flags.
- R9: A write clears `hold_empty` from the next clock. `hold_empty` returns to 1 on the clock that moves the character into the shift register, which is the clock after the write when the transmitter is idle.
- R10: `all_empty` is 1 only when the holding register and the shift register are both empty. It returns to 1 on the clock that ends the last stop tick.
- R11: If a character is waiting when the last stop tick of a frame ends, its start bit follows at once, with no idle time between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| wlen | input | 2 | Word length code, 5 + wlen bits |
| stop_long | input | 1 | Long stop period select |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select, or stuck value 0 when stuck |
| par_stick | input | 1 | Stuck parity enable |
| brk | input | 1 | Force the line low |
| loop_en | input | 1 | Loopback: hold the line at mark |
| tx | output | 1 | Serial output, idle high |
| hold_empty | output | 1 | Holding register can accept a character |
| all_empty | output | 1 | Holding and shift registers both empty |

## Verification
The hardest case to reach is a character waiting in the holding register at the exact tick on which a stop period ends. This requires a second write while the first frame is still on the line. The bench makes that write in the middle of a frame while it keeps sampling the line every cycle, then compares the whole waveform against two frames joined with no gap. The 1.5-bit stop period is only reachable with 5-bit words, so that combination gets its own frame. Tick spacing is also changed mid-run so that bit length can be seen to follow ticks rather than clocks.

// File: rtl/ser_tx_framer.sv
module ser_tx_framer #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] wlen,
  input  logic       stop_long,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       brk,
  input  logic       loop_en,
  output logic       tx,
  output logic       hold_empty,
  output logic       all_empty
);
  localparam int CW = $clog2(2 * OSR);
  localparam logic [CW-1:0] T_BIT  = CW'(OSR - 1);
  localparam logic [CW-1:0] T_HALF = CW'(OSR * 3 / 2 - 1);
  localparam logic [CW-1:0] T_TWO  = CW'(2 * OSR - 1);

  typedef enum logic [1:0] {PH_START, PH_DATA, PH_PAR, PH_STOP} ph_t;

  logic [7:0]    hold_q, shf_q;
  logic          hold_full, busy, par_q;
  ph_t           ph;
  logic [2:0]    bit_q;
  logic [CW-1:0] tcnt;

  wire [2:0]    last_bit = 3'd4 + {1'b0, wlen};
  wire [7:0]    dmask    = 8'hFF >> (2'd3 - wlen);
  wire          par_calc = par_stick ? ~par_even : ((^(hold_q & dmask)) ^ ~par_even);
  wire [CW-1:0] stop_end = !stop_long ? T_BIT : (wlen == 2'd0 ? T_HALF : T_TWO);
  wire [CW-1:0] bit_lim  = (ph == PH_STOP) ? stop_end : T_BIT;
  wire          bit_end  = busy && tick16 && (tcnt == bit_lim);
  wire          load     = hold_full && (!busy || (bit_end && ph == PH_STOP));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      shf_q     <= '0;
      par_q     <= 1'b0;
      busy      <= 1'b0;
      ph        <= PH_START;
      bit_q     <= '0;
      tcnt      <= '0;
    end else begin
      hold_full <= (hold_full && !load) || wr_en;
      if (wr_en) hold_q <= wr_data;
      if (load) begin
        shf_q <= hold_q;
        par_q <= par_calc;
        busy  <= 1'b1;
        ph    <= PH_START;
        bit_q <= '0;
        tcnt  <= '0;
      end else if (busy && tick16) begin
        if (bit_end) begin
          tcnt <= '0;
          unique case (ph)
            PH_START: ph <= PH_DATA;
            PH_DATA: begin
              shf_q <= shf_q >> 1;
              if (bit_q == last_bit) ph <= par_en ? PH_PAR : PH_STOP;
              else bit_q <= bit_q + 3'd1;
            end
            PH_PAR:  ph <= PH_STOP;
            default: busy <= 1'b0;
          endcase
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  logic frame_bit;
  always_comb begin
    unique case (ph)
      PH_START: frame_bit = 1'b0;
      PH_DATA:  frame_bit = shf_q[0];
      PH_PAR:   frame_bit = par_q;
      default:  frame_bit = 1'b1;
    endcase
    if (!busy) frame_bit = 1'b1;
  end

  assign tx         = loop_en ? 1'b1 : (brk ? 1'b0 : frame_bit);
  assign hold_empty = !hold_full;
  assign all_empty  = !hold_full && !busy;
endmodule

module ser_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic brk,
  input logic loop_en,
  input logic tx,
  input logic hold_empty,
  input logic all_empty
);
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    brk && !loop_en |-> !tx); // R7
  AST_LOOP_MARK: assert property (@(posedge clk) disable iff (rst)
    loop_en |-> tx); // R8
  AST_WRITE_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !hold_empty); // R9
  AST_EMPTY_ORDER: assert property (@(posedge clk) disable iff (rst)
    all_empty |-> hold_empty); // R10
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    all_empty && !brk |-> tx); // R1
  AST_LOAD_START: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_empty) && !brk && !loop_en |-> !tx); // R11
endmodule

bind ser_tx_framer ser_tx_framer_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .brk(brk), .loop_en(loop_en),
  .tx(tx), .hold_empty(hold_empty), .all_empty(all_empty)
);

// File: tb/sim_ser_tx_framer.sv
`timescale 1ns/100ps
module sim_ser_tx_framer;
  logic clk = 1'b0, rst = 1'b1, tick16 = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] wlen = 2'd3;
  logic stop_long = 0, par_en = 0, par_even = 0, par_stick = 0, brk = 0, loop_en = 0;
  logic tx, hold_empty, all_empty;

  int checks = 0, fails = 0, div = 1, cyc = 0;
  bit done = 0;
  logic expv [0:1023];
  int nexp = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    tick16 <= (div <= 1) ? 1'b1 : ((cyc % div) == 0);
  end

  ser_tx_framer u0 (.clk, .rst, .tick16, .wr_en, .wr_data, .wlen, .stop_long,
    .par_en, .par_even, .par_stick, .brk, .loop_en, .tx, .hold_empty, .all_empty);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic b, input int n);
    for (int i = 0; i < n; i++) begin expv[nexp] = b; nexp++; end
  endtask

  task automatic add_frame(input logic [7:0] d);
    int nb, ones;
    nb = 5 + wlen; ones = 0;
    put(1'b0, 16);
    for (int i = 0; i < nb; i++) begin put(d[i], 16); ones += d[i]; end
    if (par_en) begin
      if (par_stick) put(~par_even, 16);
      else put(par_even ? logic'(ones % 2) : logic'((ones + 1) % 2), 16);
    end
    put(1'b1, !stop_long ? 16 : (wlen == 0 ? 24 : 32));
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // compares tx per cycle against expv; optional second write at sample idx wr2_at
  task automatic run_cmp(input string tag, input int wr2_at, input logic [7:0] d2);
    int bad, first, a, e;
    bad = 0; first = -1; a = 0; e = 0;
    chk(hold_empty == 0, {tag, " R9 hold_empty after write"}, hold_empty, 0);
    for (int i = 0; i < nexp; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(hold_empty == 1, {tag, " R9 hold_empty after load"}, hold_empty, 1);
        chk(all_empty == 0, {tag, " R10 all_empty busy"}, all_empty, 0);
      end
      if (i == wr2_at + 1)
        chk(hold_empty == 0 && all_empty == 0, {tag, " R9 second write flags"}, hold_empty, 0);
      if (tx !== expv[i] && first < 0) begin first = i; a = tx; e = expv[i]; end
      if (tx !== expv[i]) bad++;
      if (i == wr2_at) begin wr_en = 1; wr_data = d2; end
      else wr_en = 0;
    end
    if (first >= 0) $display("  %s first difference at sample %0d", tag, first);
    chk(bad == 0, {tag, " R2 R3 R4 waveform"}, a, e);
    @(negedge clk);
    chk(tx == 1 && all_empty == 1, {tag, " R10 idle after frame"}, all_empty, 1);
  endtask

  task automatic t_frame(input string tag, input logic [7:0] d, input logic [1:0] wl,
                         input logic st, input logic pe, input logic ev, input logic fo);
    wlen = wl; stop_long = st; par_en = pe; par_even = ev; par_stick = fo;
    nexp = 0; add_frame(d);
    do_write(d);
    run_cmp(tag, -10, 8'h00);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(tx == 1, "R1 tx in reset", tx, 1);
    chk(hold_empty == 1 && all_empty == 1, "R1 flags in reset", all_empty, 1);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(tx == 1 && hold_empty == 1 && all_empty == 1, "R1 after reset", tx, 1);
  endtask

  task automatic t_back2back;
    wlen = 3; stop_long = 0; par_en = 1; par_even = 1; par_stick = 0;
    nexp = 0; add_frame(8'h5A); add_frame(8'hC3);
    do_write(8'h5A);
    run_cmp("R11 back-to-back", 40, 8'hC3);
  endtask

  task automatic t_break;
    @(negedge clk); brk = 1;
    #1 chk(tx == 0, "R7 break low", tx, 0);
    repeat (20) @(negedge clk);
    chk(tx == 0, "R7 break held", tx, 0);
    brk = 0;
    #1 chk(tx == 1, "R7 break released", tx, 1);
  endtask

  task automatic t_loop;
    int highs;
    wlen = 3; stop_long = 0; par_en = 0; par_stick = 0;
    loop_en = 1; highs = 0;
    do_write(8'h00);
    for (int i = 0; i < 160; i++) begin @(negedge clk); highs += tx; end
    chk(highs == 160, "R8 loopback mark", highs, 160);
    @(negedge clk);
    chk(all_empty == 1, "R8 loopback frame completes", all_empty, 1);
    loop_en = 0;
  endtask

  task automatic t_sparse;
    int lows;
    wlen = 3; stop_long = 0; par_en = 0; par_stick = 0;
    div = 3; lows = 0;
    repeat (4) @(negedge clk);
    do_write(8'hFF);
    for (int i = 0; i < 600; i++) begin @(negedge clk); lows += (tx == 0); end
    chk(lows >= 46 && lows <= 48, "R3 start bit spans 16 sparse ticks", lows, 48);
    chk(all_empty == 1, "R3 sparse frame done", all_empty, 1);
    div = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_frame("R2 8N1", 8'hA5, 2'd3, 0, 0, 0, 0);
    t_frame("R2 6N1 upper bits dropped", 8'hEA, 2'd1, 0, 0, 0, 0);
    t_frame("R4 5-bit long stop", 8'h13, 2'd0, 1, 0, 0, 0);
    t_frame("R4 6-bit two stop", 8'h2C, 2'd1, 1, 0, 0, 0);
    t_frame("R5 7-bit even", 8'h35, 2'd2, 0, 1, 1, 0);
    t_frame("R5 8-bit odd", 8'hB7, 2'd3, 0, 1, 0, 0);
    t_frame("R6 stick one", 8'h0F, 2'd3, 0, 1, 0, 1);
    t_frame("R6 stick zero", 8'h01, 2'd3, 0, 1, 1, 1);
    t_frame("R6 stick without parity", 8'h81, 2'd3, 0, 0, 0, 1);
    t_back2back();
    t_break();
    t_loop();
    t_sparse();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule